// File: doc/BRIEF.md
# Narrow-Store Register Write Adapter

This block sits between a processor store port and a small bank of 32-bit peripheral registers. Each accepted store becomes exactly one register update. The update is described by a 32-bit write word and four byte-lane enables. A store carries an address, a data word and a size code. A per-region policy code, supplied with the store, sets how stores that are narrow or misaligned are treated. Depending on the policy, such a store is expanded to a whole word or halfword shifted by the address offset, dropped when misaligned, limited to the low half of the register, merged as ordinary byte lanes, or ignored entirely.

Stores use a valid/ready handshake, and back-pressure is minimal. `st_ready` is low during reset and for the first clock after reset is released. After that it stays high. A store is taken on every rising edge where `st_valid` and `st_ready` are both high. A source that sees `st_ready` low must hold the store until it is taken. The register update happens on that same edge, and the new value is visible on the read port from the next cycle on.

A combinational read port returns the addressed register shifted right by the byte offset and masked to the read size. A strict-read input refuses narrow reads that are not word-aligned. The register index comes from the address bits above bit 1, and bits [1:0] give the byte offset.

Top module: `regwr_adapter`

## Requirements
- R1: While `rst_n` is low, every register reads 0 and `st_ready` is 0. From the second rising edge after reset is released, `st_ready` is 1.
- R2: A full-width store (size code 2 or 3) under policy 0, 1, 2, 3 or 4 drives `upd_be`=4'b1111 and writes `st_data` unchanged, whatever the offset.
- R3: Under policy 1 (word expand), a byte store (size 0) or halfword store (size 1) enables all four lanes. It writes `st_data` shifted left by 8×offset: bits moved past bit 31 are lost, and the vacated low bits are written as zero.
- R4: Under policy 2 (halfword expand), a byte or halfword store writes `st_data[15:0]`, shifted left by 8 when address bit 0 is 1 (upper bits lost, low bits zero). The value goes into the low half (lanes 1:0) when address bit 1 is 0, and into the high half (lanes 3:2) otherwise.
- R5: Under policy 3 (aligned word only), a narrow store at offset 0 writes all 32 bits of `st_data`. At any other offset it is discarded.
- R6: Under policy 4 (aligned halfword only), a narrow store with address bit 0 clear writes `st_data[15:0]` into the half selected by address bit 1. With address bit 0 set, it is discarded.
- R7: Under policy 5 (crop), a full-width store updates only bits [15:0] and leaves bits [31:16] unchanged. A narrow store acts as a plain lane write (R9) but only lanes 1:0 may be enabled.
- R8: Policy 6 (ignore) and the undefined code 7 leave the registers unchanged for stores of every size, with `upd_be`=0.
- R9: Under policy 0 (plain), a byte store enables only lane `offset` and places `st_data[7:0]` in it. A halfword store enables lanes 1:0 or 3:2, chosen by address bit 1, and places `st_data[15:0]` there.
- R10: A discarded store drives `upd_be`=0 and leaves the register unchanged.
- R11: For a read, `rd_data` is the register shifted right by 8×offset and masked to 8 bits (size 0), 16 bits (size 1) or 32 bits (size 2 or 3). When `rd_strict`=1, a narrow read with a nonzero offset gives `rd_ok`=0 and `rd_data`=0. Otherwise `rd_ok`=1.
- R12: A store takes effect on the edge where it is accepted and is readable in the next cycle. When `st_valid` or `st_ready` is low, `upd_be` is 0 and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Adapter can accept a store |
| st_addr | input | ADDR_W | Byte address: register index above bit 1, offset in [1:0] |
| st_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| st_policy | input | 3 | Region policy code 0..7 |
| st_data | input | 32 | Store data as placed on the bus |
| upd_be | output | 4 | Byte-lane enables of the current update |
| upd_data | output | 32 | Write word of the current update |
| upd_idx | output | IDX_W | Register index of the current update |
| rd_addr | input | ADDR_W | Read byte address |
| rd_size | input | 2 | Read size code, same encoding as st_size |
| rd_strict | input | 1 | Refuse misaligned narrow reads |
| rd_data | output | 32 | Read result |
| rd_ok | output | 1 | Read result is valid |

## Verification
A wrong lane or shift decision shows up at `upd_be` in the same cycle the store is presented. The damaged register contents can be read back one cycle later. A policy that writes when it should discard leaves a wrong value that stays on the read port until that register is written again. For this reason the bench reads the touched register after every store and sweeps the whole bank at the end. A lane-enable mistake under crop or ignore would otherwise be masked whenever the stale bytes happen to match the expected ones, so the bench also varies the data pattern in the upper half.

// File: rtl/regwr_pkg.sv
package regwr_pkg;
  typedef enum logic [2:0] {
    POL_PLAIN  = 3'd0,
    POL_WEXP   = 3'd1,
    POL_HEXP   = 3'd2,
    POL_WALN   = 3'd3,
    POL_HALN   = 3'd4,
    POL_CROP   = 3'd5,
    POL_IGNORE = 3'd6,
    POL_RSVD   = 3'd7
  } pol_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  localparam int LANES  = 4;
  localparam int WORD_W = 32;

  function automatic logic is_narrow(input size_e s);
    return (s == SZ_BYTE) || (s == SZ_HALF);
  endfunction
endpackage

// File: rtl/regwr_lane.sv
module regwr_lane
  import regwr_pkg::*;
(
  input  logic              en,
  input  logic [1:0]        off,
  input  logic [1:0]        size,
  input  logic [2:0]        policy,
  input  logic [WORD_W-1:0] data,
  output logic [LANES-1:0]  be,
  output logic [WORD_W-1:0] wd
);
  size_e             sz;
  pol_e              pol;
  logic              narrow;
  logic [LANES-1:0]  half_be;
  logic [LANES-1:0]  plain_be;
  logic [WORD_W-1:0] plain_wd;
  logic [15:0]       h16;

  always_comb begin
    sz       = size_e'(size);
    pol      = pol_e'(policy);
    narrow   = is_narrow(sz);
    half_be  = off[1] ? 4'b1100 : 4'b0011;
    h16      = off[0] ? {data[7:0], 8'h00} : data[15:0];
    if (sz == SZ_BYTE) begin
      plain_be = 4'b0001 << off;
      plain_wd = data << {off, 3'b000};
    end else begin
      plain_be = half_be;
      plain_wd = data << {off[1], 4'b0000};
    end

    be = '0;
    wd = data;
    unique case (pol)
      POL_PLAIN: begin
        if (narrow) begin
          be = plain_be;
          wd = plain_wd;
        end else begin
          be = '1;
        end
      end
      POL_WEXP: begin
        be = '1;
        if (narrow) wd = data << {off, 3'b000};
      end
      POL_HEXP: begin
        if (narrow) begin
          be = half_be;
          wd = {h16, h16};
        end else begin
          be = '1;
        end
      end
      POL_WALN: begin
        if (!narrow || off == 2'd0) be = '1;
      end
      POL_HALN: begin
        if (narrow) begin
          if (!off[0]) begin
            be = half_be;
            wd = {data[15:0], data[15:0]};
          end
        end else begin
          be = '1;
        end
      end
      POL_CROP: begin
        if (narrow) begin
          be = plain_be & 4'b0011;
          wd = plain_wd;
        end else begin
          be = 4'b0011;
        end
      end
      default: be = '0;
    endcase
    if (!en) be = '0;
  end
endmodule

// File: rtl/regwr_bank.sv
module regwr_bank
  import regwr_pkg::*;
#(
  parameter int NREGS = 4,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              idx,
  input  logic [LANES-1:0]              be,
  input  logic [WORD_W-1:0]             wd,
  output logic [NREGS-1:0][WORD_W-1:0]  regs_q
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic hit;
    assign hit = (idx == IDX_W'(g));
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (hit && be[b]) begin
          q <= wd[8*b +: 8];
        end
      end
      assign regs_q[g][8*b +: 8] = q;
    end
  end
endmodule

// File: rtl/regwr_rdport.sv
module regwr_rdport
  import regwr_pkg::*;
#(
  parameter int NREGS = 4,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic [NREGS-1:0][WORD_W-1:0] regs_q,
  input  logic [IDX_W-1:0]             idx,
  input  logic [1:0]                   off,
  input  logic [1:0]                   size,
  input  logic                         strict,
  output logic [WORD_W-1:0]            data,
  output logic                         ok
);
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] shifted;
  logic              refuse;
  size_e             sz;

  always_comb begin
    sz      = size_e'(size);
    word    = (int'(idx) < NREGS) ? regs_q[idx] : '0;
    shifted = word >> {off, 3'b000};
    refuse  = strict && is_narrow(sz) && (off != 2'd0);
    unique case (sz)
      SZ_BYTE: data = {24'h0, shifted[7:0]};
      SZ_HALF: data = {16'h0, shifted[15:0]};
      default: data = shifted;
    endcase
    if (refuse) data = '0;
    ok = !refuse;
  end
endmodule

// File: rtl/regwr_adapter.sv
module regwr_adapter
  import regwr_pkg::*;
#(
  parameter int NREGS = 4,
  localparam int IDX_W  = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic [2:0]        st_policy,
  input  logic [31:0]       st_data,
  output logic [3:0]        upd_be,
  output logic [31:0]       upd_data,
  output logic [IDX_W-1:0]  upd_idx,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  input  logic              rd_strict,
  output logic [31:0]       rd_data,
  output logic              rd_ok
);
  logic                         ready_q;
  logic                         take;
  logic [NREGS-1:0][WORD_W-1:0] regs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign st_ready = ready_q;
  assign take     = st_valid && ready_q;
  assign upd_idx  = st_addr[ADDR_W-1:2];

  regwr_lane u_lane (
    .en     (take),
    .off    (st_addr[1:0]),
    .size   (st_size),
    .policy (st_policy),
    .data   (st_data),
    .be     (upd_be),
    .wd     (upd_data)
  );

  regwr_bank #(.NREGS(NREGS)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (upd_idx),
    .be     (upd_be),
    .wd     (upd_data),
    .regs_q (regs_q)
  );

  regwr_rdport #(.NREGS(NREGS)) u_rd (
    .regs_q (regs_q),
    .idx    (rd_addr[ADDR_W-1:2]),
    .off    (rd_addr[1:0]),
    .size   (rd_size),
    .strict (rd_strict),
    .data   (rd_data),
    .ok     (rd_ok)
  );
endmodule

// File: rtl/regwr_adapter_chk.sv
module regwr_adapter_chk #(
  parameter int NREGS = 4,
  localparam int IDX_W  = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_ready,
  input logic [ADDR_W-1:0] st_addr,
  input logic [1:0]        st_size,
  input logic [2:0]        st_policy,
  input logic [3:0]        upd_be,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [1:0]        rd_size,
  input logic              rd_strict,
  input logic [31:0]       rd_data,
  input logic              rd_ok
);
  logic narrow;
  assign narrow = (st_size < 2'd2);

  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> st_ready); // R1
  AST_FULL_WORD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && !narrow && st_policy < 3'd5) |-> upd_be == 4'hF); // R2
  AST_WALN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_policy == 3'd3 && narrow && st_addr[1:0] != 2'd0) |-> upd_be == 4'h0); // R5
  AST_HALN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_policy == 3'd4 && narrow && st_addr[0]) |-> upd_be == 4'h0); // R6
  AST_CROP_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_policy == 3'd5) |-> upd_be[3:2] == 2'b00); // R7
  AST_IGNORE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_policy >= 3'd6) |-> upd_be == 4'h0); // R8
  AST_STRICT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strict && rd_size < 2'd2 && rd_addr[1:0] != 2'd0) |-> (!rd_ok && rd_data == 32'h0)); // R11
  AST_IDLE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_valid && st_ready) |-> upd_be == 4'h0); // R12
endmodule

bind regwr_adapter regwr_adapter_chk #(.NREGS(NREGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .st_addr   (st_addr),
  .st_size   (st_size),
  .st_policy (st_policy),
  .upd_be    (upd_be),
  .rd_addr   (rd_addr),
  .rd_size   (rd_size),
  .rd_strict (rd_strict),
  .rd_data   (rd_data),
  .rd_ok     (rd_ok)
);

// File: tb/regwr_adapter_test.sv
`timescale 1ns/1ps
module regwr_adapter_test;
  localparam int NREGS = 4;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic          st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [1:0]    st_size = '0;
  logic [2:0]    st_policy = '0;
  logic [31:0]   st_data = '0;
  logic [3:0]    upd_be;
  logic [31:0]   upd_data;
  logic [1:0]    upd_idx;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0]    rd_size = 2'd2;
  logic          rd_strict = 1'b0;
  logic [31:0]   rd_data;
  logic          rd_ok;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] mem [NREGS];

  always #5 clk = ~clk;

  regwr_adapter #(.NREGS(NREGS)) uut (.*);

  task automatic check(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Requirement-level model: returns the new register value and the lanes.
  function automatic logic [31:0] model(input logic [31:0] old, input int off, input logic [31:0] d,
                                        input int sz, input int p, output logic [3:0] be);
    logic [31:0] v;
    logic [31:0] r;
    logic [15:0] v16;
    bit narrow;
    narrow = (sz < 2);
    be = 4'h0;
    v = d;
    if (p >= 6) return old;
    if (!narrow) begin
      be = (p == 5) ? 4'h3 : 4'hF;
    end else begin
      case (p)
        0, 5: begin
          if (sz == 0) begin be[off] = 1'b1; v = d << (8 * off); end
          else begin be = (off >= 2) ? 4'hC : 4'h3; v = (off >= 2) ? d << 16 : d; end
          if (p == 5) be = be & 4'h3;
        end
        1: begin be = 4'hF; v = d << (8 * off); end
        2: begin
          v16 = d[15:0] << (8 * (off % 2));
          be = (off >= 2) ? 4'hC : 4'h3;
          v = {v16, v16};
        end
        3: if (off == 0) be = 4'hF;
        4: if (off % 2 == 0) begin be = (off >= 2) ? 4'hC : 4'h3; v = {d[15:0], d[15:0]}; end
        default: be = 4'h0;
      endcase
    end
    r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = v[8*i +: 8];
    return r;
  endfunction

  task automatic readback(input int idx, input string req);
    rd_addr = AW'(idx * 4);
    rd_size = 2'd2;
    rd_strict = 1'b0;
    #1;
    check(rd_data === mem[idx] && rd_ok === 1'b1, req, rd_data, mem[idx]);
  endtask

  task automatic store(input int addr, input logic [31:0] d, input int sz, input int p, input string req);
    logic [3:0] ebe;
    logic [31:0] nv;
    int idx;
    idx = addr / 4;
    nv = model(mem[idx], addr % 4, d, sz, p, ebe);
    @(negedge clk);
    st_addr = AW'(addr);
    st_data = d;
    st_size = 2'(sz);
    st_policy = 3'(p);
    st_valid = 1'b1;
    #1;
    check(upd_be === ebe, req, {28'h0, upd_be}, {28'h0, ebe});
    @(posedge clk);
    mem[idx] = nv;
    @(negedge clk);
    st_valid = 1'b0;
    readback(idx, req);
  endtask

  task automatic rdchk(input int addr, input int sz, input bit strict, input string req);
    logic [31:0] w;
    logic [31:0] e;
    bit eok;
    w = mem[addr / 4] >> (8 * (addr % 4));
    e = (sz == 0) ? (w & 32'hFF) : (sz == 1) ? (w & 32'hFFFF) : w;
    eok = !(strict && sz < 2 && addr % 4 != 0);
    if (!eok) e = 32'h0;
    @(negedge clk);
    rd_addr = AW'(addr);
    rd_size = 2'(sz);
    rd_strict = strict;
    #1;
    check(rd_data === e && rd_ok === eok, req, rd_data, e);
  endtask

  initial begin
    for (int i = 0; i < NREGS; i++) mem[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(st_ready === 1'b0, "R1 ready in reset", {31'h0, st_ready}, 32'h0);
    for (int i = 0; i < NREGS; i++) readback(i, "R1 reset value");
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(st_ready === 1'b1, "R1 ready after reset", {31'h0, st_ready}, 32'h1);

    store(0,  32'h11223344, 2, 0, "R2 plain word");
    store(2,  32'h000000AA, 0, 0, "R9 plain byte");
    store(6,  32'h0000BEEF, 1, 0, "R9 plain half high");
    store(9,  32'hA1B2C3D4, 0, 1, "R3 word expand byte");
    store(11, 32'h12345678, 1, 1, "R3 word expand half off3");
    store(13, 32'h0000CAFE, 0, 2, "R4 half expand odd byte");
    store(14, 32'h00001234, 1, 2, "R4 half expand high half");
    store(4,  32'h87654321, 0, 3, "R5 aligned word byte");
    store(5,  32'hDEADBEEF, 1, 3, "R5 R10 misaligned discard");
    store(2,  32'h0000BBCC, 0, 4, "R6 aligned half byte");
    store(3,  32'h99887766, 1, 4, "R6 R10 odd discard");
    store(8,  32'hFFFF5555, 2, 5, "R7 crop word");
    store(10, 32'h000000EE, 0, 5, "R7 crop high byte dropped");
    store(9,  32'h00007700, 0, 5, "R7 crop low byte");
    store(0,  32'hFFFFFFFF, 2, 6, "R8 ignore word");
    store(1,  32'hFFFFFFFF, 0, 7, "R8 undefined code");
    store(7,  32'hCAFEF00D, 3, 3, "R2 wide size misaligned");

    @(negedge clk);
    st_addr = AW'(12);
    st_size = 2'd2;
    st_policy = 3'd0;
    st_data = 32'h0BADF00D;
    st_valid = 1'b0;
    #1;
    check(upd_be === 4'h0, "R12 idle no lanes", {28'h0, upd_be}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    readback(3, "R12 idle no change");

    rdchk(1, 0, 1'b1, "R11 strict misaligned byte");
    rdchk(2, 1, 1'b1, "R11 strict misaligned half");
    rdchk(0, 1, 1'b1, "R11 strict aligned half");
    rdchk(1, 0, 1'b0, "R11 loose byte");
    rdchk(6, 1, 1'b0, "R11 loose half");
    rdchk(5, 2, 1'b1, "R11 strict word any offset");
    for (int i = 0; i < NREGS; i++) readback(i, "R12 final sweep");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule